// File: doc/BRIEF.md
# CRC-32 Frame Residue Checker

This block checks received frames whose last four bytes are a CRC-32 of the bytes before them. It treats those four bytes as ordinary data and runs one continuous GF(2) division over the whole frame. Each step is a carry-free XOR subtraction of the reflected generator. At the end it tests the leftover remainder against a fixed residue. The CRC field is never extracted or recomputed. A frame is good exactly when the remainder over message plus CRC equals the expected residue.

Bytes arrive one per cycle when `in_valid` is high. The first byte of a frame carries `in_sof`. The byte that carries `in_eof` is the last CRC byte. One cycle after that byte is accepted, `done` pulses for one cycle and `crc_ok` gives the verdict.

The parameter `INVERTED` picks the residue:
- **Plain mode** (`INVERTED=0`): the transmitter appended the raw remainder, so a good frame leaves a remainder of zero.
- **Inverted mode** (`INVERTED=1`): the transmitter appended the ones-complement of the remainder, so a good frame leaves the fixed value `0xDEBB20E3`.

The controller has two states:
- **S_IDLE**: no frame is open.
- **S_FRAME**: a frame is being absorbed.

Its transitions are:
- **open**: S_IDLE to S_FRAME, on an accepted byte with `in_sof` and no `in_eof`.
- **close**: S_FRAME to S_IDLE, on an accepted byte with `in_eof`.
- **restart**: S_FRAME to S_FRAME, on an accepted byte with `in_sof` and no `in_eof`. The register is preset again.
- **one-shot**: S_IDLE to S_IDLE, on an accepted byte with both `in_sof` and `in_eof`. This is a one-byte frame.

Top module: `crc_frame_checker`

## Requirements
- R1: The division uses the reflected generator 0xEDB88320. Each byte is absorbed LSB first (bit 0 first). For the message "123456789" followed by the CRC bytes 0x26, 0x39, 0xF4, 0xCB, inverted mode reports a good frame.
- R2: A byte with `in_valid` and `in_sof` presets the remainder to all ones before absorbing that byte. This also holds when it arrives in the middle of an open frame, and the earlier partial frame is then discarded.
- R3: While `in_valid` is low, the remainder and the state hold. `in_data`, `in_sof` and `in_eof` then have no effect on the verdict.
- R4: `done` is high for exactly one cycle, the cycle after an accepted byte with `in_eof`. A single byte carrying both `in_sof` and `in_eof` forms a complete frame.
- R5: `crc_ok` is high only together with `done`. It is high exactly when the remainder after the end-of-frame byte equals the residue.
- R6: With `INVERTED=1`, the residue is 0xDEBB20E3. A good frame is the message followed by the ones-complement of its remainder, least significant byte first. Any altered bit, or an extra zero byte before end of frame, gives `crc_ok` low.
- R7: With `INVERTED=0`, the residue is zero. A good frame is the message followed by its raw remainder, least significant byte first. A zero byte appended after the CRC still passes.
- R8: In S_IDLE, a valid byte without `in_sof` is ignored. This holds even if it carries `in_eof`: no `done` follows, and the next frame is unaffected.
- R9: During and right after reset, `done` and `crc_ok` are low and the controller is in S_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The byte on `in_data` is presented this cycle |
| in_data | input | DATA_W | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame (final CRC byte) |
| done | output | 1 | One-cycle pulse: a verdict is present |
| crc_ok | output | 1 | Frame remainder matched the residue (only with `done`) |

## Verification
The embedded properties are checked on every cycle:
- `crc_ok` never appears without `done`.
- `done` only follows an accepted end-of-frame byte.
- The remainder freezes while `in_valid` is low.
- A start byte opens a frame.
- Nothing happens from S_IDLE without a start.

Only the bench scenarios can show that the remainder arithmetic is right. These compare verdicts on the following frames against remainders computed independently:
- good frames and corrupted frames;
- a known check value;
- restarts in mid frame;
- frames with idle gaps;
- one-byte frames;
- the trailing-zero case, which behaves differently in the two modes.

// File: rtl/crc_res_pkg.sv
package crc_res_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_FRAME = 1'b1
    } chk_state_e;
endpackage

// File: rtl/crc_res_step.sv
// Combinational absorption of one data word into a reflected CRC remainder.
module crc_res_step #(
    parameter int              CRC_W  = 32,
    parameter int              DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  rem_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  rem_out
);
    logic [CRC_W-1:0] stage [0:DATA_W];

    assign stage[0] = rem_in;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        // Merge the next data bit at the LSB, then divide one step.
        logic fb;
        assign fb = stage[gi][0] ^ data_in[gi];
        assign stage[gi+1] = (stage[gi] >> 1) ^ (fb ? POLY : '0);
    end

    assign rem_out = stage[DATA_W];
endmodule

// File: rtl/crc_res_ctrl.sv
// Frame controller: tracks S_IDLE / S_FRAME and issues the verdict.
module crc_res_ctrl
    import crc_res_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eof,
    input  logic res_hit,
    output logic absorb,
    output logic restart,
    output logic done,
    output logic crc_ok
);
    chk_state_e state_q, state_d;
    logic       accept;

    assign accept  = in_valid && (in_sof || state_q == S_FRAME);
    assign absorb  = accept;
    assign restart = in_valid && in_sof;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid && in_sof && !in_eof) state_d = S_FRAME;   // open
            end
            S_FRAME: begin
                if (in_valid && in_eof) state_d = S_IDLE;              // close
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            crc_ok <= 1'b0;
        end else begin
            done   <= accept && in_eof;
            crc_ok <= accept && in_eof && res_hit;
        end
    end

    assert_sof_opens_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> (state_q == S_FRAME));

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !in_sof) |=> (!done && state_q == S_IDLE));

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (state_q == S_IDLE || $past(rst_n)));
endmodule

// File: rtl/crc_frame_checker.sv
// CRC-32 frame residue checker: divides message plus appended CRC and
// compares the final remainder with the mode's residue.
module crc_frame_checker #(
    parameter int               CRC_W       = 32,
    parameter int               DATA_W      = 8,
    parameter logic [CRC_W-1:0] POLY        = 32'hEDB88320,
    parameter bit               INVERTED    = 1'b1,
    parameter logic [CRC_W-1:0] INV_RESIDUE = 32'hDEBB20E3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              done,
    output logic              crc_ok
);
    localparam logic [CRC_W-1:0] PRESET  = '1;
    localparam logic [CRC_W-1:0] RESIDUE = INVERTED ? INV_RESIDUE : '0;

    logic [CRC_W-1:0] rem_q, rem_seed, rem_next;
    logic             absorb, restart, res_hit;

    assign rem_seed = restart ? PRESET : rem_q;

    crc_res_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
        .rem_in  (rem_seed),
        .data_in (in_data),
        .rem_out (rem_next)
    );

    assign res_hit = (rem_next == RESIDUE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rem_q <= PRESET;
        else if (absorb) rem_q <= rem_next;
    end

    crc_res_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .res_hit  (res_hit),
        .absorb   (absorb),
        .restart  (restart),
        .done     (done),
        .crc_ok   (crc_ok)
    );

    assert_hold_when_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(rem_q));

    assert_done_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_eof));

    assert_ok_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done);

    assert_sof_presets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |-> (rem_seed == PRESET));
endmodule

// File: tb/tb_crc_frame_checker.sv
module tb_crc_frame_checker;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       vld [2];
    logic       sof [2];
    logic       eof [2];
    logic [7:0] dat [2];
    logic       dn  [2];
    logic       ok  [2];

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    crc_frame_checker #(.INVERTED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(vld[0]), .in_data(dat[0]),
        .in_sof(sof[0]), .in_eof(eof[0]), .done(dn[0]), .crc_ok(ok[0]));

    crc_frame_checker #(.INVERTED(1'b0)) dut_plain (
        .clk(clk), .rst_n(rst_n), .in_valid(vld[1]), .in_data(dat[1]),
        .in_sof(sof[1]), .in_eof(eof[1]), .done(dn[1]), .crc_ok(ok[1]));

    typedef struct packed {
        logic [3:0]  len;
        logic [63:0] msg;
        logic [31:0] err;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'd1, 64'h0000000000000000, 32'h00000000, 1'b1},
        '{4'd4, 64'h0000000034333231, 32'h00000000, 1'b1},
        '{4'd8, 64'h0123456789ABCDEF, 32'h00000001, 1'b0},
        '{4'd3, 64'h0000000000C0FFEE, 32'h80000000, 1'b0},
        '{4'd0, 64'h0000000000000000, 32'h00000000, 1'b1},
        '{4'd8, 64'hFFFFFFFFFFFFFFFF, 32'h00000000, 1'b1},
        '{4'd5, 64'h0000000000000000, 32'h00010000, 1'b0}
    };

    logic [7:0] fb [16];
    int         flen;

    function automatic logic [31:0] ref_step(input logic [31:0] r, input logic [7:0] b);
        logic [31:0] x;
        x = r ^ {24'h0, b};
        for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
        return x;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic build(input int inst, input vec_t v);
        logic [31:0] r, c;
        r = 32'hFFFFFFFF;
        for (int i = 0; i < int'(v.len); i++) begin
            fb[i] = v.msg[8*i +: 8];
            r = ref_step(r, fb[i]);
        end
        c = ((inst == 0) ? ~r : r) ^ v.err;
        for (int i = 0; i < 4; i++) fb[int'(v.len) + i] = c[8*i +: 8];
        flen = int'(v.len) + 4;
    endtask

    task automatic idle_cycle(input int inst);
        @(negedge clk);
        vld[inst] = 1'b0; dat[inst] = 8'h5A; sof[inst] = 1'b1; eof[inst] = 1'b1;
    endtask

    // Drives fb[0..flen-1]; returns at the negedge where the verdict is visible.
    task automatic drive_frame(input int inst, input bit gaps);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            vld[inst] = 1'b1; dat[inst] = fb[i];
            sof[inst] = (i == 0); eof[inst] = (i == flen - 1);
            if (gaps && i < flen - 1) idle_cycle(inst);
        end
        @(negedge clk);
        vld[inst] = 1'b0; sof[inst] = 1'b0; eof[inst] = 1'b0;
    endtask

    task automatic verdict(input int inst, input string tag, input logic exp);
        chk({tag, " done"}, dn[inst], 1'b1);
        chk({tag, " crc_ok"}, ok[inst], exp);
        @(negedge clk);
        chk({tag, " done one cycle"}, dn[inst], 1'b0);
        chk({tag, " crc_ok low"}, ok[inst], 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            vld[i] = 1'b0; sof[i] = 1'b0; eof[i] = 1'b0; dat[i] = 8'h00;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 done in reset", dn[0], 1'b0);
        chk("R9 crc_ok in reset", ok[0], 1'b0);
        chk("R9 plain done in reset", dn[1], 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 done after reset", dn[0], 1'b0);

        // Vector table in both modes (R6 inverted, R7 plain, R5 verdict)
        for (int inst = 0; inst < 2; inst++) begin
            for (int k = 0; k < 7; k++) begin
                build(inst, VECS[k]);
                drive_frame(inst, 1'b0);
                verdict(inst, (inst == 0) ? "R6 vector" : "R7 vector", VECS[k].exp);
            end
        end

        // R1: known check value of "123456789" is 0xCBF43926
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        fb[9] = 8'h26; fb[10] = 8'h39; fb[11] = 8'hF4; fb[12] = 8'hCB; flen = 13;
        drive_frame(0, 1'b0);
        verdict(0, "R1 check value inverted", 1'b1);
        fb[9] = 8'hD9; fb[10] = 8'hC6; fb[11] = 8'h0B; fb[12] = 8'h34;
        drive_frame(1, 1'b0);
        verdict(1, "R1 check value plain", 1'b1);

        // R3: idle gaps with garbage on data/sof/eof while valid is low
        build(0, VECS[1]);
        drive_frame(0, 1'b1);
        verdict(0, "R3 gaps", 1'b1);

        // R8: stray bytes in S_IDLE without sof, last one with eof
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            vld[0] = 1'b1; dat[0] = 8'hC3 + 8'(i); sof[0] = 1'b0; eof[0] = (i == 2);
        end
        @(negedge clk);
        vld[0] = 1'b0; eof[0] = 1'b0;
        chk("R8 no done for stray eof", dn[0], 1'b0);
        build(0, VECS[5]);
        drive_frame(0, 1'b0);
        verdict(0, "R8 frame after stray bytes", 1'b1);

        // R2: partial frame then restart with a fresh sof
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            vld[0] = 1'b1; dat[0] = 8'h99 - 8'(i); sof[0] = (i == 0); eof[0] = 1'b0;
        end
        build(0, VECS[1]);
        drive_frame(0, 1'b0);
        verdict(0, "R2 restart mid frame", 1'b1);

        // R7 / R6: zero byte appended after the CRC
        build(1, VECS[1]);
        fb[flen] = 8'h00; flen++;
        drive_frame(1, 1'b0);
        verdict(1, "R7 trailing zero plain", 1'b1);
        build(0, VECS[1]);
        fb[flen] = 8'h00; flen++;
        drive_frame(0, 1'b0);
        verdict(0, "R6 trailing zero inverted", 1'b0);

        // R4: single-byte frame with sof and eof together
        fb[0] = 8'h00; flen = 1;
        drive_frame(0, 1'b0);
        verdict(0, "R4 one-byte frame",
                (ref_step(32'hFFFFFFFF, 8'h00) == 32'hDEBB20E3));

        // R4: back-to-back frames
        build(0, VECS[0]);
        drive_frame(0, 1'b0);
        chk("R4 first of pair done", dn[0], 1'b1);
        build(0, VECS[4]);
        drive_frame(0, 1'b0);
        verdict(0, "R4 second of pair", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule